// File: doc/BRIEF.md
# Selectable Synchronous Clock Divider

This block takes one input clock and produces a set of divided clocks whose rising edges are aligned, because every divider stage advances from the same gated internal clock. A run-time ratio select picks between a slow set (divide by 2, 4, 8) and a fast set (divide by 1, 2, 4). In the fast set the lowest output is the gated input clock itself.

An active-low run input starts and freezes the dividers. It is captured on the falling edge of the input clock, so the internal clock is only ever gated while it is low and no shortened pulse can appear. The ratio select passes through the same falling-edge register, and is only taken while the block is running. An active-high divider reset, sampled on the clock, clears every stage to a known phase. This lets several instances on one clock be brought into step.

Top module: `clkdiv_sel_top`

## Requirements
- R1: With the slow ratio set (fsel = 0 when captured), q_out[0], q_out[1] and q_out[2] toggle as the input clock divided by 2, 4 and 8, each high for the first half of its period.
- R2: With the fast ratio set (fsel = 1 when captured), q_out[0] equals the input clock while running, and q_out[1], q_out[2] are the input clock divided by 2 and 4.
- R3: The rising edges of all outputs fall on the same input rising edge wherever their periods line up; the first enabled rising edge after reset drives every output high together.
- R4: While en_n is captured high, every output holds its value through any number of input edges, and q_out[0] in the fast set stays low; fsel changes are ignored until running again.
- R5: mr high at an input rising edge clears the dividers and q_out[2:1] at that edge; at the following falling edge the run gate and ratio select return to the stopped slow state, so every output is low from then until released.
- R6: en_n and fsel are captured only on the input falling edge, and no output ever shows a high or low pulse shorter than half an input period, including across run/stop and ratio changes.
- R7: After mr is released, the output sequence restarts exactly as after power-up, independent of the phase before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; dividers advance on its rising edge |
| mr | input | 1 | Active-high divider reset, sampled on the clock |
| en_n | input | 1 | Active-low run control, captured on the falling edge |
| fsel | input | 1 | Ratio set select: 0 slow (2/4/8), 1 fast (1/2/4) |
| q_out | output | NUM_OUT (3) | Divided clock outputs, index 0 fastest |

## Verification
The hardest situation to reach is a ratio change or a stop landing on an awkward phase, for example switching from the fast set while the pass-through output is high, or stopping in the middle of a divide-by-8 cycle. Only there could a short pulse appear. The stimulus toggles fsel and en_n at many different points of the divider count, including single-cycle stop requests. A pulse-width monitor on every output checks each change against half an input period. A reset pulse is also applied in the middle of a run to show that the phase realigns to the power-up sequence.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic {
    RATIO_SLOW = 1'b0,
    RATIO_FAST = 1'b1
  } ratio_e;
endpackage

// File: rtl/clkdiv_gate_ctrl.sv
module clkdiv_gate_ctrl
  import clkdiv_pkg::*;
(
  input  logic   clk,
  input  logic   mr,
  input  logic   en_n,
  input  logic   fsel,
  output logic   run_q,
  output ratio_e ratio_q
);
  // Captured on the falling edge: the gated clock is low whenever these move.
  always_ff @(negedge clk) begin
    if (mr) begin
      run_q   <= 1'b0;
      ratio_q <= RATIO_SLOW;
    end else begin
      run_q <= ~en_n;
      if (!en_n) ratio_q <= ratio_e'(fsel);
    end
  end

  // The gate closes on the falling edge after a stop request.
  assert_gate_close_R6: assert property (@(negedge clk) disable iff (mr)
    en_n |=> !run_q);
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             mr,
  input  logic             run,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);
  // Down counter: the first step from zero sets every bit, aligning all rises.
  always_comb begin
    cnt_nxt = cnt_q;
    if (run) cnt_nxt = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (mr) cnt_q <= '0;
    else    cnt_q <= cnt_nxt;
  end

  assert_release_clean_R5: assert property (@(posedge clk) disable iff (mr)
    $fell(mr) |-> (cnt_q == '0));

  assert_count_hold_R4: assert property (@(posedge clk) disable iff (mr)
    !run |=> $stable(cnt_q));
endmodule

// File: rtl/clkdiv_outsel.sv
module clkdiv_outsel
  import clkdiv_pkg::*;
#(
  parameter int NUM_OUT = 3
) (
  input  logic               clk,
  input  logic               mr,
  input  logic               run,
  input  ratio_e             ratio,
  input  logic [NUM_OUT-1:0] cnt_nxt,
  output logic [NUM_OUT-1:0] q_reg
);
  logic [NUM_OUT-1:0] pick;
  logic               fast;

  assign fast = (ratio == RATIO_FAST);

  // Fast set shifts every registered output down by one stage; the lowest
  // register is parked low because the pass-through path drives output 0.
  generate
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_pick
      if (i == 0) begin : g_low
        assign pick[i] = fast ? 1'b0 : cnt_nxt[0];
      end else begin : g_up
        assign pick[i] = fast ? cnt_nxt[i-1] : cnt_nxt[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (mr)       q_reg <= '0;
    else if (run) q_reg <= pick;
  end

  assert_out_hold_R4: assert property (@(posedge clk) disable iff (mr)
    !run |=> $stable(q_reg));
endmodule

// File: rtl/clkdiv_sel_top.sv
module clkdiv_sel_top
  import clkdiv_pkg::*;
#(
  parameter int NUM_OUT = 3
) (
  input  logic               clk,
  input  logic               mr,
  input  logic               en_n,
  input  logic               fsel,
  output logic [NUM_OUT-1:0] q_out
);
  localparam int CNT_W = NUM_OUT;

  logic               run_q;
  ratio_e             ratio_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   cnt_nxt;
  logic [NUM_OUT-1:0] q_reg;
  logic               fast;

  clkdiv_gate_ctrl u_ctrl (
    .clk     (clk),
    .mr      (mr),
    .en_n    (en_n),
    .fsel    (fsel),
    .run_q   (run_q),
    .ratio_q (ratio_q)
  );

  clkdiv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .mr      (mr),
    .run     (run_q),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  clkdiv_outsel #(.NUM_OUT(NUM_OUT)) u_sel (
    .clk     (clk),
    .mr      (mr),
    .run     (run_q),
    .ratio   (ratio_q),
    .cnt_nxt (cnt_nxt),
    .q_reg   (q_reg)
  );

  assign fast = (ratio_q == RATIO_FAST);

  // Divide-by-1 path: clock gated by a falling-edge register, so it is glitch free.
  assign q_out[0] = (clk & run_q & fast) | (q_reg[0] & ~fast);

  generate
    if (NUM_OUT > 1) begin : g_upper
      assign q_out[NUM_OUT-1:1] = q_reg[NUM_OUT-1:1];

      assert_align_R3: assert property (@(posedge clk) disable iff (mr)
        (cnt_q == '1) |-> (&q_reg[NUM_OUT-1:1]));
    end
  endgenerate
endmodule

// File: tb/clkdiv_sel_top_test.sv
`timescale 1ns/1ps
module clkdiv_sel_top_test;
  localparam int N = 3;
  localparam realtime HALF = 2.5;

  logic clk = 1'b0;
  logic mr = 1'b1;
  logic en_n = 1'b0;
  logic fsel = 1'b0;
  logic [N-1:0] q_out;

  int n_checks = 0;
  int n_fail = 0;
  string cur_tag = "R5";
  bit armed = 1'b0;

  // Behavioural reference state
  int m_phase = 0;
  bit m_run = 1'b0;
  bit m_fast = 1'b0;
  bit m_r [N];

  realtime last_t [N];

  clkdiv_sel_top #(.NUM_OUT(N)) uut (
    .clk   (clk),
    .mr    (mr),
    .en_n  (en_n),
    .fsel  (fsel),
    .q_out (q_out)
  );

  always #(HALF) clk = ~clk;

  // High for the first half of a 2^(k+1)-step period counted from step 1.
  function automatic bit half_hi(int ph, int k);
    int d = 1 << (k + 1);
    return (((ph + 64 - 1) % d) < (d / 2));
  endfunction

  always @(negedge clk) begin
    if (mr) begin
      m_run = 1'b0;
      m_fast = 1'b0;
    end else begin
      m_run = !en_n;
      if (!en_n) m_fast = fsel;
    end
  end

  always @(posedge clk) begin
    if (mr) begin
      m_phase = 0;
      for (int i = 0; i < N; i++) m_r[i] = 1'b0;
    end else if (m_run) begin
      m_phase = (m_phase + 1) % (1 << N);
      for (int i = 0; i < N; i++) begin
        if (m_fast) m_r[i] = (i == 0) ? 1'b0 : half_hi(m_phase, i - 1);
        else        m_r[i] = half_hi(m_phase, i);
      end
    end
  end

  task automatic compare(input bit clk_lvl);
    bit exp_v;
    for (int i = 0; i < N; i++) begin
      if (i == 0) exp_v = (clk_lvl & m_run & m_fast) | (m_r[0] & !m_fast);
      else        exp_v = m_r[i];
      n_checks++;
      if (q_out[i] !== exp_v) begin
        n_fail++;
        $display("FAIL %s: q_out[%0d] actual %b expected %b at %0t",
                 cur_tag, i, q_out[i], exp_v, $time);
      end
    end
  endtask

  always @(posedge clk) if (armed) begin #2; compare(1'b1); end
  always @(negedge clk) if (armed) begin #2; compare(1'b0); end

  // R6: pulse-width monitor on every output
  always @(q_out) begin
    for (int i = 0; i < N; i++) begin
      if (q_out[i] !== q_out_prev[i]) begin
        if (armed && last_t[i] > 0) begin
          n_checks++;
          if ($realtime - last_t[i] < HALF - 0.1) begin
            n_fail++;
            $display("FAIL R6: q_out[%0d] pulse %0t ns, expected >= %0t ns",
                     i, $realtime - last_t[i], HALF);
          end
        end
        last_t[i] = $realtime;
      end
    end
    q_out_prev = q_out;
  end
  logic [N-1:0] q_out_prev = '0;

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_val(input string tag, input logic [N-1:0] exp_v);
    n_checks++;
    if (q_out !== exp_v) begin
      n_fail++;
      $display("FAIL %s: q_out actual %b expected %b", tag, q_out, exp_v);
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) last_t[i] = 0;
    // Reset state
    cycles(4);
    #1;
    check_val("R5 reset state", '0);
    armed = 1'b1;

    // Slow set, first edge aligns all outputs
    cur_tag = "R1";
    @(posedge clk); #1; mr = 1'b0;
    @(posedge clk); #2;
    check_val("R3 first edge after reset", '1);
    cur_tag = "R3";
    cycles(8);
    cur_tag = "R1";
    cycles(30);

    // Hold, ignore fsel while held, resume
    cur_tag = "R4";
    en_n = 1'b1;
    cycles(3);
    fsel = 1'b1;
    cycles(9);
    fsel = 1'b0;
    cycles(2);
    en_n = 1'b0;
    cur_tag = "R1";
    cycles(20);

    // Fast set
    cur_tag = "R2";
    fsel = 1'b1;
    cycles(40);
    cur_tag = "R4";
    en_n = 1'b1;
    cycles(7);
    en_n = 1'b0;
    cur_tag = "R2";
    cycles(15);

    // Reset mid-run realigns the phase
    cur_tag = "R5";
    cycles(3);
    mr = 1'b1;
    cycles(3);
    cur_tag = "R7";
    mr = 1'b0;
    @(posedge clk); #2;
    check_val("R7 restart aligned", '1);
    cycles(20);

    // Ratio changes at many phases, single-cycle stops
    cur_tag = "R6";
    for (int k = 0; k < 12; k++) begin
      fsel = ~fsel;
      cycles(k % 5 + 1);
      en_n = 1'b1;
      cycles(k % 3 + 1);
      en_n = 1'b0;
      cycles(k % 7 + 2);
    end
    cycles(20);

    armed = 1'b0;
    #10;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #50000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule